// File: doc/BRIEF.md
# Hitless Reference Switch Sequencer

This block is the control state machine of a clock PLL that switches between references without a phase hit. It arms once the loop reports lock for the first time. When lock is then lost, for example because the reference multiplexer was reselected, it turns off the phase detector and forces narrow loop bandwidth. If the phase build-out option is enabled, it then asks the feedback path to slip its phase by whole oscillator cycles, and it waits for that request to be acknowledged. After that it turns the detector back on and waits for the loop to stay in window for a run of consecutive compares. A resume timer of about 175 ns then runs, and when it expires the sequencer returns to wide bandwidth and re-arms.

The sequencer has six states. `ST_IDLE` waits for the first lock, and lock goes to `ST_ARMED`. In `ST_ARMED`, loss of lock goes to `ST_HOLD`, which has the detector off and bandwidth narrow. `ST_HOLD` goes either to `ST_BUILD` (build-out enabled) or to `ST_RELOCK`, and `ST_BUILD` goes to `ST_RELOCK` on acknowledge. In `ST_RELOCK`, a complete run of in-window compares goes to `ST_RESUME`. In `ST_RESUME`, timer expiry goes back to `ST_ARMED`, and loss of lock aborts to `ST_RELOCK`. The loop filter, the oscillator and the phase comparator are outside this block. The comparator supplies one compare result per compare event.

Top module: `hitless_switch_seq`

## Requirements
- R1: After reset the state is `ST_IDLE`, the phase detector is enabled, no build-out request is present and the bandwidth output follows the narrow-bandwidth pin.
- R2: In `ST_IDLE` a low lock flag is ignored and the state stays `ST_IDLE`. A high lock flag moves the state to `ST_ARMED` on the next cycle.
- R3: In `ST_ARMED`, a low lock flag moves the state to `ST_HOLD` on the next cycle. In that state the detector is disabled and narrow bandwidth is forced.
- R4: `ST_HOLD` lasts exactly one cycle. It moves to `ST_BUILD` when the build-out enable is high and to `ST_RELOCK` otherwise.
- R5: The build-out request is high for only the first cycle of `ST_BUILD`. The state stays `ST_BUILD`, with the detector disabled, until the acknowledge input is high.
- R6: In `ST_RELOCK` the detector is enabled and narrow bandwidth stays forced. The state moves to `ST_RESUME` on the RUN_LEN-th consecutive compare strobe that is in window (8 by default). An out-of-window compare clears the run, and cycles without a compare strobe neither add to it nor clear it.
- R7: `ST_RESUME` lasts exactly ceil(RESUME_PS / CLK_PERIOD_PS) cycles (44 by default), then returns to `ST_ARMED` with wide bandwidth.
- R8: A low lock flag during `ST_RESUME` moves the state back to `ST_RELOCK` without passing through `ST_BUILD`, and the in-window run starts again from zero.
- R9: The bandwidth output is narrow whenever the narrow-bandwidth pin is high, in any state.
- R10: The status encoding is IDLE=0, ARMED=1, HOLD=2, BUILD=3, RELOCK=4, RESUME=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| locked | input | 1 | Loop lock flag, 1 = locked |
| cmp_valid | input | 1 | A reference/feedback compare occurred this cycle |
| cmp_in_win | input | 1 | That compare was inside the lock window |
| narrow_pin | input | 1 | External narrow-bandwidth request |
| pbo_en | input | 1 | Phase build-out option enable |
| pbo_ack | input | 1 | Build-out completed acknowledge |
| pd_en | output | 1 | Phase detector enable |
| bw_narrow | output | 1 | Effective narrow-bandwidth select |
| pbo_req | output | 1 | Single-cycle build-out request |
| seq_state | output | 3 | Sequencer status (R10 encoding) |

## Verification
The bench feeds an in-window run that is broken by a miss after five hits. A design that fails to clear the run would leave relock early. The bench also puts compare-free gaps inside a run, and a design that clears on those gaps would stay in `ST_RELOCK` too long. The resume phase is checked cycle by cycle against the computed timer length, so an off-by-one timer returns to wide bandwidth one cycle early or late. A loss of lock in the middle of the timer must go straight back to relock without a second build-out request and must need a full fresh run. The build-out request is checked to be a single cycle even while the acknowledge is withheld for several cycles.

// File: rtl/hs_pkg.sv
package hs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARMED  = 3'd1,
        ST_HOLD   = 3'd2,
        ST_BUILD  = 3'd3,
        ST_RELOCK = 3'd4,
        ST_RESUME = 3'd5
    } hs_state_e;
endpackage

// File: rtl/hs_run_counter.sv
// Counts consecutive in-window compares; a miss clears, idle cycles hold.
module hs_run_counter #(
    parameter int RUN_LEN = 8,
    localparam int RUN_W  = $clog2(RUN_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic valid,
    input  logic hit,
    output logic done
);
    logic [RUN_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (valid) begin
            cnt <= hit ? cnt + 1'b1 : '0;
        end
    end

    assign done = !clr && valid && hit && (cnt == RUN_W'(RUN_LEN - 1));
endmodule

// File: rtl/hs_resume_timer.sv
// Down-counter loaded on entry to the resume phase; expires on its last cycle.
module hs_resume_timer #(
    parameter int LOAD   = 44,
    localparam int TMR_W = $clog2(LOAD + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expire
);
    logic [TMR_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= TMR_W'(LOAD);
        end else if (run && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = run && (cnt == TMR_W'(1));
endmodule

// File: rtl/hitless_switch_seq.sv
module hitless_switch_seq #(
    parameter int CLK_PERIOD_PS = 4000,
    parameter int RESUME_PS     = 175000,
    parameter int RUN_LEN       = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       locked,
    input  logic       cmp_valid,
    input  logic       cmp_in_win,
    input  logic       narrow_pin,
    input  logic       pbo_en,
    input  logic       pbo_ack,
    output logic       pd_en,
    output logic       bw_narrow,
    output logic       pbo_req,
    output logic [2:0] seq_state
);
    import hs_pkg::*;

    localparam int TIMER_CYC = (RESUME_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;

    hs_state_e state, state_nx;
    logic      req_sent;
    logic      run_done;
    logic      tmr_expire;
    logic      run_clr;
    logic      tmr_load;

    assign run_clr  = (state != ST_RELOCK);
    assign tmr_load = (state == ST_RELOCK) && run_done;

    hs_run_counter #(.RUN_LEN(RUN_LEN)) u_run (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (run_clr),
        .valid (cmp_valid),
        .hit   (cmp_in_win),
        .done  (run_done)
    );

    hs_resume_timer #(.LOAD(TIMER_CYC)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .run    (state == ST_RESUME),
        .expire (tmr_expire)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (locked)     state_nx = ST_ARMED;
            ST_ARMED:  if (!locked)    state_nx = ST_HOLD;
            ST_HOLD:   state_nx = pbo_en ? ST_BUILD : ST_RELOCK;
            ST_BUILD:  if (pbo_ack)    state_nx = ST_RELOCK;
            ST_RELOCK: if (run_done)   state_nx = ST_RESUME;
            ST_RESUME: begin
                if (!locked)         state_nx = ST_RELOCK;
                else if (tmr_expire) state_nx = ST_ARMED;
            end
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_sent <= 1'b0;
        else        req_sent <= (state == ST_BUILD);
    end

    always_comb begin
        pd_en     = 1'b1;
        bw_narrow = narrow_pin;
        pbo_req   = 1'b0;
        seq_state = state;
        unique case (state)
            ST_IDLE, ST_ARMED: ;
            ST_HOLD: begin
                pd_en     = 1'b0;
                bw_narrow = 1'b1;
            end
            ST_BUILD: begin
                pd_en     = 1'b0;
                bw_narrow = 1'b1;
                pbo_req   = !req_sent;
            end
            ST_RELOCK, ST_RESUME: bw_narrow = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/hitless_switch_seq_chk.sv
module hitless_switch_seq_chk #(
    parameter int TIMER_CYC = 44
) (
    input logic       clk,
    input logic       rst_n,
    input logic       locked,
    input logic       cmp_valid,
    input logic       pbo_en,
    input logic       narrow_pin,
    input logic       bw_narrow,
    input logic       pbo_req,
    input logic [2:0] seq_state
);
    import hs_pkg::*;

    localparam int CW = $clog2(TIMER_CYC + 2);
    logic [CW-1:0] res_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   res_cnt <= '0;
        else if (seq_state == ST_RESUME) res_cnt <= res_cnt + 1'b1;
        else                          res_cnt <= '0;
    end

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_IDLE && !locked) |=> (seq_state == ST_IDLE));
    a_r3_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_ARMED && !locked) |=> (seq_state == ST_HOLD));
    a_r4_hold_build: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_HOLD && pbo_en) |=> (seq_state == ST_BUILD));
    a_r4_hold_relock: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_HOLD && !pbo_en) |=> (seq_state == ST_RELOCK));
    a_r5_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pbo_req |=> !pbo_req);
    a_r6_no_strobe_stay: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_RELOCK && !cmp_valid) |=> (seq_state == ST_RELOCK));
    a_r7_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_RESUME) |-> (res_cnt < CW'(TIMER_CYC)));
    a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == ST_RESUME && !locked) |=> (seq_state == ST_RELOCK));
    a_r9_pin_or: assert property (@(posedge clk) disable iff (!rst_n)
        narrow_pin |-> bw_narrow);
endmodule

bind hitless_switch_seq hitless_switch_seq_chk #(
    .TIMER_CYC((RESUME_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .locked     (locked),
    .cmp_valid  (cmp_valid),
    .pbo_en     (pbo_en),
    .narrow_pin (narrow_pin),
    .bw_narrow  (bw_narrow),
    .pbo_req    (pbo_req),
    .seq_state  (seq_state)
);

// File: tb/hitless_switch_seq_tb.sv
module hitless_switch_seq_tb;
    localparam int PERIOD_PS = 4000;
    localparam int RES_PS    = 175000;
    localparam int EXP_TMR   = (RES_PS + PERIOD_PS - 1) / PERIOD_PS;

    localparam logic [2:0] S_IDLE = 3'd0, S_ARM = 3'd1, S_HOLD = 3'd2,
                           S_BLD = 3'd3, S_REL = 3'd4, S_RES = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic locked = 1'b0, cmp_valid = 1'b0, cmp_in_win = 1'b0;
    logic narrow_pin = 1'b0, pbo_en = 1'b0, pbo_ack = 1'b0;
    logic pd_en, bw_narrow, pbo_req;
    logic [2:0] seq_state;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [2:0] st;
        logic       pd;
        logic       bw;
        logic       rq;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #2ns clk = ~clk;

    hitless_switch_seq #(.CLK_PERIOD_PS(PERIOD_PS), .RESUME_PS(RES_PS), .RUN_LEN(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .locked(locked), .cmp_valid(cmp_valid),
        .cmp_in_win(cmp_in_win), .narrow_pin(narrow_pin), .pbo_en(pbo_en),
        .pbo_ack(pbo_ack), .pd_en(pd_en), .bw_narrow(bw_narrow),
        .pbo_req(pbo_req), .seq_state(seq_state)
    );

    // Driver: inputs were just set at a negedge; push what the next edge must produce.
    task automatic cy(input logic [2:0] st, input logic pd, input logic bw,
                      input logic rq, input string tag);
        exp_t e;
        e.st = st; e.pd = pd; e.bw = bw; e.rq = rq; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1ns;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (seq_state !== e.st || pd_en !== e.pd || bw_narrow !== e.bw || pbo_req !== e.rq) begin
                    fails++;
                    $display("FAIL %s: got st=%0d pd=%0b bw=%0b rq=%0b exp st=%0d pd=%0b bw=%0b rq=%0b",
                             e.tag, seq_state, pd_en, bw_narrow, pbo_req, e.st, e.pd, e.bw, e.rq);
                end
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got running exp finished");
            finish_run();
        end
    end

    initial begin
        // R1: reset values, observed before any clock edge is needed
        #1ns;
        checks++;
        if (seq_state !== S_IDLE || pd_en !== 1'b1 || pbo_req !== 1'b0 || bw_narrow !== 1'b0) begin
            fails++;
            $display("FAIL R1: got st=%0d pd=%0b rq=%0b bw=%0b exp 0 1 0 0", seq_state, pd_en, pbo_req, bw_narrow);
        end
        narrow_pin = 1'b1;
        #1ns;
        checks++;
        if (bw_narrow !== 1'b1) begin
            fails++;
            $display("FAIL R1: got bw=%0b exp 1", bw_narrow);
        end
        narrow_pin = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R2: no arming without lock, then arm
        for (int i = 0; i < 3; i++) cy(S_IDLE, 1, 0, 0, "R2");
        locked = 1'b1;
        cy(S_ARM, 1, 0, 0, "R2");
        cy(S_ARM, 1, 0, 0, "R10");

        // R9: pin forces narrow while armed
        narrow_pin = 1'b1;
        cy(S_ARM, 1, 1, 0, "R9");
        narrow_pin = 1'b0;
        cy(S_ARM, 1, 0, 0, "R9");

        // R3/R4: trigger without build-out
        pbo_en = 1'b0;
        locked = 1'b0;
        cy(S_HOLD, 0, 1, 0, "R3");
        locked = 1'b1;
        cy(S_REL, 1, 1, 0, "R4");

        // R6: five hits, then a miss clears the run
        cmp_valid = 1'b1; cmp_in_win = 1'b1;
        for (int i = 0; i < 5; i++) cy(S_REL, 1, 1, 0, "R6");
        cmp_in_win = 1'b0;
        cy(S_REL, 1, 1, 0, "R6");
        cmp_in_win = 1'b1;
        for (int i = 0; i < 4; i++) cy(S_REL, 1, 1, 0, "R6");
        cmp_valid = 1'b0;
        for (int i = 0; i < 2; i++) cy(S_REL, 1, 1, 0, "R6");
        cmp_valid = 1'b1;
        for (int i = 0; i < 3; i++) cy(S_REL, 1, 1, 0, "R6");
        cy(S_RES, 1, 1, 0, "R6");
        cmp_valid = 1'b0;

        // R7: resume lasts EXP_TMR cycles
        for (int i = 1; i < EXP_TMR; i++) cy(S_RES, 1, 1, 0, "R7");
        cy(S_ARM, 1, 0, 0, "R7");

        // R5: build-out path with delayed acknowledge
        pbo_en = 1'b1;
        locked = 1'b0;
        cy(S_HOLD, 0, 1, 0, "R3");
        locked = 1'b1;
        cy(S_BLD, 0, 1, 1, "R5");
        for (int i = 0; i < 2; i++) cy(S_BLD, 0, 1, 0, "R5");
        pbo_ack = 1'b1;
        cy(S_REL, 1, 1, 0, "R5");
        pbo_ack = 1'b0;

        cmp_valid = 1'b1; cmp_in_win = 1'b1;
        for (int i = 0; i < 7; i++) cy(S_REL, 1, 1, 0, "R6");
        cy(S_RES, 1, 1, 0, "R6");
        cmp_valid = 1'b0;
        for (int i = 0; i < 10; i++) cy(S_RES, 1, 1, 0, "R7");

        // R8: abort during resume, fresh run needed, no build-out again
        locked = 1'b0;
        cy(S_REL, 1, 1, 0, "R8");
        locked = 1'b1;
        cmp_valid = 1'b1;
        for (int i = 0; i < 7; i++) cy(S_REL, 1, 1, 0, "R8");
        cy(S_RES, 1, 1, 0, "R8");
        cmp_valid = 1'b0;
        for (int i = 1; i < EXP_TMR; i++) cy(S_RES, 1, 1, 0, "R7");
        cy(S_ARM, 1, 0, 0, "R7");
        cy(S_ARM, 1, 0, 0, "R2");

        @(negedge clk);
        done = 1'b1;
        finish_run();
    end
endmodule